// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a virtual page against an in-memory hashed page table. A translation starts with a one-cycle start pulse. With that pulse the block takes a 32-bit effective address, the virtual segment identifier from the segment register the caller has selected, the access kind (store or not), and the table base and hash mask. The block forms a hash from the segment identifier and the page index and turns it into the address of a group of eight entries. It reads the entries one at a time over a single-outstanding word-read/byte-write memory port. If the primary group yields nothing, it searches a second group found from the complemented hash.

On a match the block reads the second word of the entry and reports both entry words and the translated real address. If the entry's referenced bit is clear, or its changed bit is clear on a store, the block writes single bytes back into the entry. When the changed bit is clear on a non-store access, it raises a flag that asks the caller to treat the page as read-only. Permission checks and exception generation belong to the caller. The memory port is big-endian: byte offset 0 of a word is its bits 31:24.

Top module: `hpt_walker`

## Requirements
- R1: `seg_index` always equals bits 31:28 of `eff_addr`; the caller uses it to pick the segment register whose identifier field is driven on `seg_vsid`.
- R2: The primary group starts at `tbl_base + (((vsid ^ eff_addr[27:12]) << 6) & tbl_mask)`, with the hash zero-extended to 32 bits. Entry k of a group sits at group start + 8*k, and entries are visited in the order 0 to 7.
- R3: An entry's first word matches only when bit 31 (valid) is 1, bit 6 equals the current pass (0 primary, 1 secondary), bits 30:7 equal the segment identifier and bits 5:0 equal `eff_addr[27:22]`.
- R4: If no entry of the primary group matches, the block searches a secondary group whose start uses the 32-bit bitwise complement of the hash in the R2 formula.
- R5: For every entry, the word at offset 0 is read before the word at offset 4. The offset-4 word is read only directly after the offset-0 word of the same entry.
- R6: On a hit, `done` comes with `hit`=1, `pte_hi`/`pte_lo` equal to the two words as read, and `real_addr` = {`pte_lo[31:12]`, `eff_addr[11:0]`}.
- R7: If bit 8 (referenced) of the second word is clear, the block writes the byte at entry offset 6 with `pte_lo[15:8] | 8'h01`.
- R8: If bit 7 (changed) is clear on a store, the block writes the byte at entry offset 7 with `pte_lo[7:0] | 8'h80`, after any referenced-byte write. No byte is written when both bits are already set.
- R9: `wr_suppress` is 1 at `done` exactly when a hit entry has its changed bit clear and the access is not a store; no changed-byte write occurs then.
- R10: A miss in both groups ends with `done` and `hit`=0, after exactly 16 first-word reads and no writes.
- R11: `done` is a single-cycle pulse. While `mem_req` is high and `mem_ack` is low, the request and its address stay unchanged. After reset the block is idle with `done`, `hit` and `mem_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a walk (accepted when idle) |
| eff_addr | input | 32 | Effective address to translate |
| seg_vsid | input | 24 | Segment identifier from the selected segment register |
| is_store | input | 1 | Access is a store |
| tbl_base | input | 32 | Byte address of the page table |
| tbl_mask | input | 32 | Mask applied to the scaled hash |
| seg_index | output | 4 | Segment register selector |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a single-byte write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 8 | Byte to write |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read word |
| done | output | 1 | Walk finished (one cycle) |
| hit | output | 1 | Matching entry found |
| pte_hi | output | 32 | First entry word |
| pte_lo | output | 32 | Second entry word, before write-back |
| real_addr | output | 32 | Translated real address |
| wr_suppress | output | 1 | Treat page as read-only until a store sets the changed bit |

## Verification
The hardest case to reach is a table that contains near-misses for the same tag. These are an entry with the valid bit clear, an entry whose pass bit says secondary while the primary group is being searched, and an entry in the secondary group whose pass bit says primary. The bench computes both group addresses itself and plants these decoys ahead of the real entry, so a walk that ends at the right slot with the right number of reads shows that each field of the match took part. Write-back paths are reached by placing entries with every referenced/changed combination and comparing the updated table words and the write log.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    localparam int WORD_W      = 32;
    localparam int VSID_W      = 24;
    localparam int API_W       = 6;
    localparam int PAGE_SHIFT  = 12;
    localparam int ENTRY_BYTES = 8;

    // Byte offsets inside one entry (big-endian word layout).
    localparam logic [2:0] OFF_HI  = 3'd0;
    localparam logic [2:0] OFF_LO  = 3'd4;
    localparam logic [2:0] OFF_REF = 3'd6;
    localparam logic [2:0] OFF_CHG = 3'd7;

    // Bit positions inside the second entry word.
    localparam int REF_BIT = 8;
    localparam int CHG_BIT = 7;

    localparam logic [7:0] REF_SET = 8'h01;
    localparam logic [7:0] CHG_SET = 8'h80;

    typedef struct packed {
        logic              valid;
        logic [VSID_W-1:0] vsid;
        logic              second;
        logic [API_W-1:0]  api;
    } hpte_hi_t;

    typedef struct packed {
        logic [VSID_W-1:0] vsid;
        logic [API_W-1:0]  api;
    } walk_tag_t;

    typedef enum logic [2:0] {
        W_IDLE,
        W_FETCH_HI,
        W_FETCH_LO,
        W_SET_REF,
        W_SET_CHG,
        W_FINISH
    } walk_st_t;

    function automatic walk_tag_t tag_of(input logic [VSID_W-1:0] vsid,
                                         input logic [27:0] ea);
        walk_tag_t t;
        t.vsid = vsid;
        t.api  = ea[27:22];
        return t;
    endfunction

endpackage

// File: rtl/hpt_hash_unit.sv
module hpt_hash_unit
    import hpt_pkg::*;
#(
    parameter int GROUP_SHIFT = 6
) (
    input  logic [27:0]        ea,
    input  logic [VSID_W-1:0]  vsid,
    input  logic               secondary,
    input  logic [WORD_W-1:0]  tbl_base,
    input  logic [WORD_W-1:0]  tbl_mask,
    output logic [WORD_W-1:0]  group_addr,
    output walk_tag_t          tag
);
    localparam int PIDX_W = 28 - PAGE_SHIFT;

    logic [WORD_W-1:0] hash_p;
    logic [WORD_W-1:0] hash_sel;
    logic [WORD_W-1:0] scaled;

    always_comb begin
        hash_p   = WORD_W'(vsid) ^ WORD_W'(ea[27:PAGE_SHIFT]);
        hash_sel = secondary ? ~hash_p : hash_p;
        scaled   = hash_sel << GROUP_SHIFT;
        group_addr = tbl_base + (scaled & tbl_mask);
        tag      = tag_of(vsid, ea);
    end

    if (PIDX_W != 16) begin : g_bad_page
        initial $error("page index width must be 16");
    end

endmodule

// File: rtl/hpt_entry_match.sv
module hpt_entry_match
    import hpt_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  walk_tag_t         tag,
    input  logic              pass,
    output logic              match
);
    hpte_hi_t e;

    always_comb begin
        e     = hpte_hi_t'(word);
        match = e.valid && (e.second == pass) &&
                (e.vsid == tag.vsid) && (e.api == tag.api);
    end

endmodule

// File: rtl/hpt_rc_update.sv
module hpt_rc_update
    import hpt_pkg::*;
(
    input  logic [15:0] lo_bits,
    input  logic        is_store,
    output logic        need_ref,
    output logic        need_chg,
    output logic        suppress,
    output logic [7:0]  ref_byte,
    output logic [7:0]  chg_byte
);
    always_comb begin
        need_ref = !lo_bits[REF_BIT];
        need_chg = !lo_bits[CHG_BIT] && is_store;
        suppress = !lo_bits[CHG_BIT] && !is_store;
        ref_byte = lo_bits[15:8] | REF_SET;
        chg_byte = lo_bits[7:0]  | CHG_SET;
    end

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int GROUP_ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] eff_addr,
    input  logic [23:0] seg_vsid,
    input  logic        is_store,
    input  logic [31:0] tbl_base,
    input  logic [31:0] tbl_mask,
    output logic [3:0]  seg_index,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        done,
    output logic        hit,
    output logic [31:0] pte_hi,
    output logic [31:0] pte_lo,
    output logic [31:0] real_addr,
    output logic        wr_suppress
);
    localparam int SLOT_W      = (GROUP_ENTRIES > 1) ? $clog2(GROUP_ENTRIES) : 1;
    localparam int GROUP_SHIFT = $clog2(GROUP_ENTRIES * ENTRY_BYTES);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_ENTRIES - 1);

    walk_st_t           st;
    logic [27:0]        ea_q;
    logic [VSID_W-1:0]  vsid_q;
    logic               store_q;
    logic               pass_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [WORD_W-1:0]  w_hi_q;
    logic [WORD_W-1:0]  w_lo_q;
    logic               hit_q;
    logic [WORD_W-1:0]  raddr_q;
    logic               supp_q;

    logic [WORD_W-1:0]  group_addr;
    walk_tag_t          tag;
    logic               slot_match;
    logic [WORD_W-1:0]  entry_addr;
    logic [15:0]        rc_src;
    logic               rc_need_ref;
    logic               rc_need_chg;
    logic               rc_suppress;
    logic [7:0]         rc_ref_byte;
    logic [7:0]         rc_chg_byte;

    assign seg_index = eff_addr[31:28];

    hpt_hash_unit #(.GROUP_SHIFT(GROUP_SHIFT)) u_hash (
        .ea         (ea_q),
        .vsid       (vsid_q),
        .secondary  (pass_q),
        .tbl_base   (tbl_base),
        .tbl_mask   (tbl_mask),
        .group_addr (group_addr),
        .tag        (tag)
    );

    hpt_entry_match u_match (
        .word  (mem_rdata),
        .tag   (tag),
        .pass  (pass_q),
        .match (slot_match)
    );

    assign rc_src = (st == W_FETCH_LO) ? mem_rdata[15:0] : w_lo_q[15:0];

    hpt_rc_update u_rc (
        .lo_bits  (rc_src),
        .is_store (store_q),
        .need_ref (rc_need_ref),
        .need_chg (rc_need_chg),
        .suppress (rc_suppress),
        .ref_byte (rc_ref_byte),
        .chg_byte (rc_chg_byte)
    );

    assign entry_addr = group_addr + (WORD_W'(slot_q) << $clog2(ENTRY_BYTES));

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = entry_addr;
        mem_wdata = rc_ref_byte;
        unique case (st)
            W_FETCH_HI: begin
                mem_req  = 1'b1;
                mem_addr = entry_addr + WORD_W'(OFF_HI);
            end
            W_FETCH_LO: begin
                mem_req  = 1'b1;
                mem_addr = entry_addr + WORD_W'(OFF_LO);
            end
            W_SET_REF: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = entry_addr + WORD_W'(OFF_REF);
                mem_wdata = rc_ref_byte;
            end
            W_SET_CHG: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = entry_addr + WORD_W'(OFF_CHG);
                mem_wdata = rc_chg_byte;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= W_IDLE;
            ea_q    <= '0;
            vsid_q  <= '0;
            store_q <= 1'b0;
            pass_q  <= 1'b0;
            slot_q  <= '0;
            w_hi_q  <= '0;
            w_lo_q  <= '0;
            hit_q   <= 1'b0;
            raddr_q <= '0;
            supp_q  <= 1'b0;
        end else begin
            unique case (st)
                W_IDLE: begin
                    if (start) begin
                        ea_q    <= eff_addr[27:0];
                        vsid_q  <= seg_vsid;
                        store_q <= is_store;
                        pass_q  <= 1'b0;
                        slot_q  <= '0;
                        w_hi_q  <= '0;
                        w_lo_q  <= '0;
                        hit_q   <= 1'b0;
                        raddr_q <= '0;
                        supp_q  <= 1'b0;
                        st      <= W_FETCH_HI;
                    end
                end
                W_FETCH_HI: begin
                    if (mem_ack) begin
                        w_hi_q <= mem_rdata;
                        if (slot_match) begin
                            st <= W_FETCH_LO;
                        end else if (slot_q == LAST_SLOT) begin
                            if (!pass_q) begin
                                pass_q <= 1'b1;
                                slot_q <= '0;
                            end else begin
                                st <= W_FINISH;
                            end
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                W_FETCH_LO: begin
                    if (mem_ack) begin
                        w_lo_q  <= mem_rdata;
                        hit_q   <= 1'b1;
                        raddr_q <= {mem_rdata[31:PAGE_SHIFT], ea_q[PAGE_SHIFT-1:0]};
                        supp_q  <= rc_suppress;
                        if (rc_need_ref)      st <= W_SET_REF;
                        else if (rc_need_chg) st <= W_SET_CHG;
                        else                  st <= W_FINISH;
                    end
                end
                W_SET_REF: begin
                    if (mem_ack) st <= rc_need_chg ? W_SET_CHG : W_FINISH;
                end
                W_SET_CHG: begin
                    if (mem_ack) st <= W_FINISH;
                end
                W_FINISH: st <= W_IDLE;
                default:  st <= W_IDLE;
            endcase
        end
    end

    assign done        = (st == W_FINISH);
    assign hit         = hit_q;
    assign pte_hi      = w_hi_q;
    assign pte_lo      = w_lo_q;
    assign real_addr   = raddr_q;
    assign wr_suppress = supp_q;

endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [7:0]  mem_wdata,
    input logic        done,
    input logic        hit,
    input logic [31:0] pte_lo,
    input logic [31:0] real_addr,
    input logic        wr_suppress
);
    logic [31:0] last_hi_addr;

    always_ff @(posedge clk) begin
        if (rst) last_hi_addr <= '0;
        else if (mem_req && mem_ack && !mem_we && !mem_addr[2])
            last_hi_addr <= mem_addr;
    end

    // R11: held request
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R11: single-cycle completion
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: no traffic while reporting
    assert_quiet_done_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);

    // R5: second word follows first word of same entry
    assert_word_order_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we && mem_addr[2] |-> last_hi_addr == mem_addr - 32'd4);

    // R7: write offsets and referenced byte content
    assert_ref_byte_R7: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && mem_addr[2:0] == 3'd6 |-> mem_wdata[0]);

    assert_write_slot_R7: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> mem_addr[2:1] == 2'b11);

    // R8: changed byte content
    assert_chg_byte_R8: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && mem_addr[2:0] == 3'd7 |-> mem_wdata[7]);

    // R9: suppress only with a hit
    assert_suppress_hit_R9: assert property (@(posedge clk) disable iff (rst)
        done && wr_suppress |-> hit && !pte_lo[7]);

    // R6: page number of the result
    assert_rpn_R6: assert property (@(posedge clk) disable iff (rst)
        done && hit |-> real_addr[31:12] == pte_lo[31:12]);

endmodule

bind hpt_walker hpt_walker_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .done        (done),
    .hit         (hit),
    .pte_lo      (pte_lo),
    .real_addr   (real_addr),
    .wr_suppress (wr_suppress)
);

// File: tb/hpt_walker_bench.sv
`timescale 1ns/1ps
module hpt_walker_bench;

    localparam logic [31:0] BASE = 32'h0001_0000;
    localparam logic [31:0] MASK = 32'h0000_3FC0;
    localparam int MEM_WORDS = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] eff_addr = '0;
    logic [23:0] seg_vsid = '0;
    logic        is_store = 1'b0;
    logic [3:0]  seg_index;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done, hit, wr_suppress;
    logic [31:0] pte_hi, pte_lo, real_addr;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] mem [MEM_WORDS];
    int          rd_cnt, wr_cnt, order_bad;
    logic [31:0] prev_rd;
    logic [31:0] wr_a [4];
    logic [7:0]  wr_d [4];

    always #2 clk = ~clk;

    hpt_walker u_hpt_walker (
        .clk(clk), .rst(rst), .start(start), .eff_addr(eff_addr),
        .seg_vsid(seg_vsid), .is_store(is_store), .tbl_base(BASE),
        .tbl_mask(MASK), .seg_index(seg_index), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .hit(hit),
        .pte_hi(pte_hi), .pte_lo(pte_lo), .real_addr(real_addr),
        .wr_suppress(wr_suppress)
    );

    function automatic int widx(input logic [31:0] a);
        logic [31:0] d;
        d = (a - BASE) >> 2;
        return int'(d[11:0]);
    endfunction

    // Memory model: one request at a time, acknowledged the next cycle.
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                automatic int i = widx(mem_addr);
                automatic int sh = (3 - int'(mem_addr[1:0])) * 8;
                mem[i] = (mem[i] & ~(32'hFF << sh)) | (32'(mem_wdata) << sh);
                if (wr_cnt < 4) begin
                    wr_a[wr_cnt] = mem_addr;
                    wr_d[wr_cnt] = mem_wdata;
                end
                wr_cnt = wr_cnt + 1;
            end else begin
                mem_rdata <= mem[widx(mem_addr)];
                if (mem_addr[2] && prev_rd != mem_addr - 32'd4) order_bad = order_bad + 1;
                prev_rd = mem_addr;
                rd_cnt = rd_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    function automatic logic [31:0] grp_of(input logic [31:0] ea,
                                           input logic [23:0] v, input bit sec);
        logic [31:0] h;
        h = {8'h00, v ^ {8'h00, ea[27:12]}};
        if (sec) h = ~h;
        return BASE + ((h << 6) & MASK);
    endfunction

    function automatic logic [31:0] mk_hi(input logic [31:0] ea,
                                          input logic [23:0] v, input bit h);
        return {1'b1, v, h, ea[27:22]};
    endfunction

    function automatic logic [31:0] mk_lo(input logic [19:0] rpn, input bit r, input bit c);
        return {rpn, 3'b000, r, c, 7'b0000010};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'h0;
        rd_cnt = 0; wr_cnt = 0; order_bad = 0; prev_rd = 32'hFFFF_FFFF;
        for (int i = 0; i < 4; i++) begin wr_a[i] = '0; wr_d[i] = '0; end
    endtask

    task automatic put(input logic [31:0] grp, input int slot,
                       input logic [31:0] hi, input logic [31:0] lo);
        mem[widx(grp + 32'(slot * 8))]     = hi;
        mem[widx(grp + 32'(slot * 8) + 4)] = lo;
    endtask

    task automatic walk(input logic [31:0] ea, input logic [23:0] v, input bit st);
        int n;
        @(negedge clk);
        eff_addr = ea; seg_vsid = v; is_store = st; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 400) begin @(negedge clk); n++; end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R11: actual no done expected done");
        end
    endtask

    task automatic t_reset();
        chk("R11 reset done", 32'(done), 32'd0);
        chk("R11 reset hit", 32'(hit), 32'd0);
        chk("R11 reset req", 32'(mem_req), 32'd0);
    endtask

    task automatic t_primary();
        logic [31:0] ea = 32'h3ABC_D123;
        logic [23:0] v = 24'h012345;
        logic [31:0] g = grp_of(ea, v, 0);
        logic [31:0] lo = mk_lo(20'h89ABC, 1, 1);
        clear_all();
        put(g, 0, mk_hi(ea, v, 0) & 32'h7FFF_FFFF, mk_lo(20'h11111, 1, 1));
        put(g, 1, mk_hi(ea, v, 1), mk_lo(20'h22222, 1, 1));
        put(g, 2, mk_hi(ea, v, 0) ^ 32'h0000_0001, mk_lo(20'h33333, 1, 1));
        put(g, 5, mk_hi(ea, v, 0), lo);
        walk(ea, v, 0);
        chk("R1 seg index", 32'(seg_index), 32'h3);
        chk("R3 hit", 32'(hit), 32'd1);
        chk("R6 pte_hi", pte_hi, mk_hi(ea, v, 0));
        chk("R6 pte_lo", pte_lo, lo);
        chk("R6 real addr", real_addr, 32'h89AB_C123);
        chk("R2 R3 reads to slot 5", 32'(rd_cnt), 32'd7);
        chk("R8 no writes", 32'(wr_cnt), 32'd0);
        chk("R9 no suppress", 32'(wr_suppress), 32'd0);
        chk("R5 order", 32'(order_bad), 32'd0);
        @(negedge clk);
        chk("R11 done pulse", 32'(done), 32'd0);
    endtask

    task automatic t_secondary();
        logic [31:0] ea = 32'h5004_2FFF;
        logic [23:0] v = 24'h000777;
        logic [31:0] gp = grp_of(ea, v, 0);
        logic [31:0] gs = grp_of(ea, v, 1);
        logic [31:0] lo = mk_lo(20'hFEDCB, 1, 1);
        clear_all();
        put(gp, 3, mk_hi(ea, v, 1), mk_lo(20'h44444, 1, 1));
        put(gs, 0, mk_hi(ea, v, 0), mk_lo(20'h55555, 1, 1));
        put(gs, 7, mk_hi(ea, v, 1), lo);
        walk(ea, v, 1);
        chk("R4 hit secondary", 32'(hit), 32'd1);
        chk("R4 pte_hi", pte_hi, mk_hi(ea, v, 1));
        chk("R4 reads", 32'(rd_cnt), 32'd17);
        chk("R6 real addr", real_addr, 32'hFEDC_BFFF);
        chk("R5 order", 32'(order_bad), 32'd0);
        chk("R1 seg index", 32'(seg_index), 32'h5);
    endtask

    task automatic t_miss();
        logic [31:0] ea = 32'h7123_4000;
        logic [23:0] v = 24'h00ABCD;
        clear_all();
        put(grp_of(ea, v, 1), 2, mk_hi(ea, v ^ 24'h1, 1), mk_lo(20'h1, 0, 0));
        walk(ea, v, 1);
        chk("R10 hit low", 32'(hit), 32'd0);
        chk("R10 reads", 32'(rd_cnt), 32'd16);
        chk("R10 writes", 32'(wr_cnt), 32'd0);
    endtask

    task automatic t_ref_load();
        logic [31:0] ea = 32'h9000_1555;
        logic [23:0] v = 24'h000042;
        logic [31:0] g = grp_of(ea, v, 0);
        logic [31:0] lo = mk_lo(20'h0A0B0, 0, 0);
        clear_all();
        put(g, 0, mk_hi(ea, v, 0), lo);
        walk(ea, v, 0);
        chk("R7 one write", 32'(wr_cnt), 32'd1);
        chk("R7 write addr", wr_a[0], g + 32'd6);
        chk("R7 write data", 32'(wr_d[0]), 32'(lo[15:8] | 8'h01));
        chk("R7 table word", mem[widx(g + 4)], lo | 32'h100);
        chk("R9 suppress", 32'(wr_suppress), 32'd1);
        chk("R6 pte_lo as read", pte_lo, lo);
    endtask

    task automatic t_store_both();
        logic [31:0] ea = 32'hC0FF_E010;
        logic [23:0] v = 24'h0F0F0F;
        logic [31:0] g = grp_of(ea, v, 0);
        logic [31:0] lo = mk_lo(20'h12345, 0, 0);
        clear_all();
        put(g, 2, mk_hi(ea, v, 0), lo);
        walk(ea, v, 1);
        chk("R8 two writes", 32'(wr_cnt), 32'd2);
        chk("R7 first addr", wr_a[0], g + 32'd22);
        chk("R8 second addr", wr_a[1], g + 32'd23);
        chk("R8 second data", 32'(wr_d[1]), 32'(lo[7:0] | 8'h80));
        chk("R8 table word", mem[widx(g + 20)], lo | 32'h180);
        chk("R9 no suppress on store", 32'(wr_suppress), 32'd0);
    endtask

    task automatic t_store_chg_only();
        logic [31:0] ea = 32'hE000_7ABC;
        logic [23:0] v = 24'h00BEEF;
        logic [31:0] g = grp_of(ea, v, 0);
        logic [31:0] lo = mk_lo(20'h0CAFE, 1, 0);
        clear_all();
        put(g, 4, mk_hi(ea, v, 0), lo);
        walk(ea, v, 1);
        chk("R8 one write", 32'(wr_cnt), 32'd1);
        chk("R8 addr", wr_a[0], g + 32'd39);
        chk("R8 table word", mem[widx(g + 36)], lo | 32'h80);
    endtask

    task automatic t_load_clean();
        logic [31:0] ea = 32'h1234_5678;
        logic [23:0] v = 24'hABCDEF;
        logic [31:0] g = grp_of(ea, v, 0);
        clear_all();
        put(g, 6, mk_hi(ea, v, 0), mk_lo(20'h77777, 1, 0));
        walk(ea, v, 0);
        chk("R9 suppress on load", 32'(wr_suppress), 32'd1);
        chk("R9 no changed write", 32'(wr_cnt), 32'd0);
        chk("R2 group with high hash bits", 32'(rd_cnt), 32'd8);
    endtask

    initial begin
        clear_all();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_primary();
        t_secondary();
        t_miss();
        t_ref_load();
        t_store_both();
        t_store_chg_only();
        t_load_clean();
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R11: actual hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule